// File: doc/BRIEF.md
# Register Initialization Command Sequencer

This block replays a list of configuration commands against a register bus. Each command is two 32-bit words in a command memory. Once a start request is accepted, the sequencer fetches the commands from a first index up to, but not including, an end index. It decodes each one and issues the resulting transactions on a register-bus master port.

The port handles several kinds of traffic:
- single reads and writes;
- writes that carry an indirect-access qualifier;
- word strings copied out of a data memory;
- zero fills;
- bulk copies split into bounded chunks.

A fill or bulk copy longer than the staging capacity is rejected. An undecodable opcode is also rejected. In both cases the command is skipped, the error flag is raised and the sequence carries on. A one-cycle done pulse ends every run.

The bus master port follows valid/ready rules. A beat is offered with `bus_valid_o` and is complete in the cycle where `bus_ready_i` is also high. While ready is low, the beat and all its payload stay unchanged, and the sequencer makes no further progress, so the bus can stall it for as long as it needs. Both memory ports are plain synchronous reads: the data appears one cycle after the read strobe.

Top module: `rinit_sequencer`

## Requirements
- R1: Command i occupies command-memory words 2i (opcode in bits [31:24], 24-bit register offset in bits [23:0]) and 2i+1 (payload). A run executes indices first through last-1 in ascending order. `done_o` is high for exactly one cycle after the final command. When first >= last, `done_o` pulses with no bus traffic.
- R2: Opcode 1 issues one bus read beat at the offset, with `bus_we_o`=0, `bus_ind_o`=0 and `bus_last_o`=1. The returned data is discarded.
- R3: Opcode 2 issues one write of the payload word to the offset with `bus_ind_o`=0. Opcode 3 does the same with `bus_ind_o`=1.
- R4: Opcodes 4 and 5 take the data-memory start index from payload [15:0] and the word count from payload [31:16]. Beat k writes data-memory word start+k to offset+4k. `bus_last_o` is set only on the final beat, and `bus_ind_o` equals 1 only for opcode 5. A count of zero issues nothing and is not an error.
- R5: Opcode 6 writes zero to offset+4k for a count equal to the whole payload word.
- R6: Opcode 8 copies like opcode 4, without the indirect qualifier, but in chunks. `bus_last_o` is set on every beat whose index k satisfies k mod MAX_CHUNK = MAX_CHUNK-1, and on the final beat. The address keeps advancing by 4 per word across chunk boundaries.
- R7: An opcode 6 or 8 whose count exceeds STAGE_BYTES/4 words (16 by default) issues no beats and raises `err_o`. A count of exactly 16 is accepted.
- R8: Opcode 7, opcode 0, and any opcode above 8 issue no beats and raise `err_o`. Sequencing then continues with the next index.
- R9: `err_o` stays set until the next accepted start, which clears it.
- R10: While `bus_valid_o` is high and `bus_ready_i` is low, the valid signal, the address, the data and the qualifiers hold steady.
- R11: `busy_o` is high from the cycle after an accepted start through the done cycle. A start request while busy is ignored. While idle, the block makes no bus or memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| first_idx_i | input | IDXW | First command index of the run |
| end_idx_i | input | IDXW | Exclusive end command index |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky error flag for the current run |
| cmd_rd_o | output | 1 | Command memory read strobe |
| cmd_addr_o | output | IDXW+1 | Command memory word address |
| cmd_data_i | input | 32 | Command memory read data, one cycle after strobe |
| dat_rd_o | output | 1 | Data memory read strobe |
| dat_addr_o | output | DAW | Data memory word address |
| dat_data_i | input | 32 | Data memory read data, one cycle after strobe |
| bus_valid_o | output | 1 | Bus beat offered |
| bus_ready_i | input | 1 | Bus accepts the offered beat |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_ind_o | output | 1 | Indirect-access qualifier |
| bus_last_o | output | 1 | Final beat of a burst or chunk |
| bus_addr_o | output | 24 | Register byte address |
| bus_wdata_o | output | 32 | Write data |

## Verification
Two events can land on the same beat: a chunk boundary and the end of a bulk transfer. This happens for fills or copies whose length is an exact multiple of the chunk size, such as 8 and 16 words. Those lengths are run while the bus ready line is withheld at random, so stalls fall on the coinciding beat. The bench then checks three things: each recorded beat carries exactly one last marker at the expected index, the addresses keep stepping by four across the boundary, and no extra beat follows the final one.

// File: rtl/rinit_pkg.sv
package rinit_pkg;
  localparam logic [7:0] OPC_RD = 8'd1;
  localparam logic [7:0] OPC_WR = 8'd2;
  localparam logic [7:0] OPC_IW = 8'd3;
  localparam logic [7:0] OPC_SW = 8'd4;
  localparam logic [7:0] OPC_SI = 8'd5;
  localparam logic [7:0] OPC_ZR = 8'd6;
  localparam logic [7:0] OPC_ZP = 8'd7;
  localparam logic [7:0] OPC_WB = 8'd8;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH0, S_FETCH1, S_DECODE, S_LOAD, S_WAITD, S_BEAT, S_NEXT, S_FIN
  } seq_state_t;

  typedef enum logic [2:0] {
    K_SKIP, K_READ, K_WRITE, K_COPY, K_FILL
  } cmd_kind_t;
endpackage

// File: rtl/rinit_decode.sv
module rinit_decode
  import rinit_pkg::*;
#(
  parameter int STAGE_WORDS = 16,
  parameter int LENW        = 16
) (
  input  logic [7:0]      op_i,
  input  logic [31:0]     pay_i,
  output cmd_kind_t       kind_o,
  output logic            ind_o,
  output logic            chunked_o,
  output logic            bad_o,
  output logic [LENW-1:0] len_o,
  output logic [15:0]     src_o
);
  localparam logic [31:0] STAGE_LIM = 32'(STAGE_WORDS);

  always_comb begin
    kind_o    = K_SKIP;
    ind_o     = 1'b0;
    chunked_o = 1'b0;
    bad_o     = 1'b0;
    len_o     = LENW'(1);
    src_o     = pay_i[15:0];
    case (op_i)
      OPC_RD: kind_o = K_READ;
      OPC_WR: kind_o = K_WRITE;
      OPC_IW: begin
        kind_o = K_WRITE;
        ind_o  = 1'b1;
      end
      OPC_SW, OPC_SI: begin
        ind_o  = (op_i == OPC_SI);
        len_o  = LENW'(pay_i[31:16]);
        kind_o = (pay_i[31:16] == 16'd0) ? K_SKIP : K_COPY;
      end
      OPC_ZR: begin
        if (pay_i > STAGE_LIM) begin
          bad_o = 1'b1;
        end else begin
          chunked_o = 1'b1;
          len_o     = LENW'(pay_i);
          kind_o    = (pay_i == 32'd0) ? K_SKIP : K_FILL;
        end
      end
      OPC_WB: begin
        if (32'(pay_i[31:16]) > STAGE_LIM) begin
          bad_o = 1'b1;
        end else begin
          chunked_o = 1'b1;
          len_o     = LENW'(pay_i[31:16]);
          kind_o    = (pay_i[31:16] == 16'd0) ? K_SKIP : K_COPY;
        end
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rinit_beat.sv
module rinit_beat #(
  parameter int LENW      = 16,
  parameter int MAX_CHUNK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [LENW-1:0] len_i,
  input  logic            step_i,
  output logic [LENW-1:0] beat_o,
  output logic            final_o,
  output logic            chunk_end_o
);
  localparam int CW = $clog2(MAX_CHUNK + 1);
  localparam logic [CW-1:0] POS_TOP = CW'(MAX_CHUNK - 1);

  logic [LENW-1:0] len_q;
  logic [CW-1:0]   pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_o <= '0;
      len_q  <= '0;
      pos_q  <= '0;
    end else if (load_i) begin
      beat_o <= '0;
      len_q  <= len_i;
      pos_q  <= '0;
    end else if (step_i) begin
      beat_o <= beat_o + 1'b1;
      pos_q  <= (pos_q == POS_TOP) ? '0 : pos_q + 1'b1;
    end
  end

  assign final_o     = (beat_o == len_q - 1'b1);
  assign chunk_end_o = (pos_q == POS_TOP) || final_o;
endmodule

// File: rtl/rinit_sequencer.sv
module rinit_sequencer
  import rinit_pkg::*;
#(
  parameter int IDXW        = 6,
  parameter int DAW         = 8,
  parameter int MAX_CHUNK   = 4,
  parameter int STAGE_BYTES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [IDXW-1:0] first_idx_i,
  input  logic [IDXW-1:0] end_idx_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            cmd_rd_o,
  output logic [IDXW:0]   cmd_addr_o,
  input  logic [31:0]     cmd_data_i,
  output logic            dat_rd_o,
  output logic [DAW-1:0]  dat_addr_o,
  input  logic [31:0]     dat_data_i,
  output logic            bus_valid_o,
  input  logic            bus_ready_i,
  output logic            bus_we_o,
  output logic            bus_ind_o,
  output logic            bus_last_o,
  output logic [23:0]     bus_addr_o,
  output logic [31:0]     bus_wdata_o
);
  localparam int STAGE_WORDS = STAGE_BYTES / 4;
  localparam int LENW        = 16;

  seq_state_t      state_q;
  logic [IDXW-1:0] idx_q, end_q;
  logic [31:0]     w0_q, wdata_q;
  cmd_kind_t       kind_q;
  logic            ind_q, chunked_q;
  logic [15:0]     src_q;

  cmd_kind_t       dk;
  logic            d_ind, d_chunk, d_bad;
  logic [LENW-1:0] d_len;
  logic [15:0]     d_src;

  logic [LENW-1:0] beat;
  logic            final_beat, chunk_end, accept;

  rinit_decode #(.STAGE_WORDS(STAGE_WORDS), .LENW(LENW)) u_dec (
    .op_i(w0_q[31:24]), .pay_i(cmd_data_i), .kind_o(dk), .ind_o(d_ind),
    .chunked_o(d_chunk), .bad_o(d_bad), .len_o(d_len), .src_o(d_src)
  );

  assign accept = (state_q == S_BEAT) && bus_ready_i;

  rinit_beat #(.LENW(LENW), .MAX_CHUNK(MAX_CHUNK)) u_beat (
    .clk(clk), .rst_n(rst_n), .load_i(state_q == S_DECODE), .len_i(d_len),
    .step_i(accept), .beat_o(beat), .final_o(final_beat), .chunk_end_o(chunk_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      end_q     <= '0;
      w0_q      <= '0;
      wdata_q   <= '0;
      kind_q    <= K_SKIP;
      ind_q     <= 1'b0;
      chunked_q <= 1'b0;
      src_q     <= '0;
      err_o     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          idx_q   <= first_idx_i;
          end_q   <= end_idx_i;
          err_o   <= 1'b0;
          state_q <= (first_idx_i < end_idx_i) ? S_FETCH0 : S_FIN;
        end
        S_FETCH0: state_q <= S_FETCH1;
        S_FETCH1: begin
          w0_q    <= cmd_data_i;
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          kind_q    <= dk;
          ind_q     <= d_ind;
          chunked_q <= d_chunk;
          src_q     <= d_src;
          wdata_q   <= (dk == K_WRITE) ? cmd_data_i : 32'd0;
          if (d_bad) err_o <= 1'b1;
          case (dk)
            K_SKIP:  state_q <= S_NEXT;
            K_COPY:  state_q <= S_LOAD;
            default: state_q <= S_BEAT;
          endcase
        end
        S_LOAD:  state_q <= S_WAITD;
        S_WAITD: begin
          wdata_q <= dat_data_i;
          state_q <= S_BEAT;
        end
        S_BEAT: if (bus_ready_i) begin
          if (final_beat)              state_q <= S_NEXT;
          else if (kind_q == K_COPY)   state_q <= S_LOAD;
        end
        S_NEXT: begin
          if ((IDXW+1)'(idx_q) + 1'b1 == (IDXW+1)'(end_q)) begin
            state_q <= S_FIN;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_FETCH0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign cmd_rd_o    = (state_q == S_FETCH0) || (state_q == S_FETCH1);
  assign cmd_addr_o  = {idx_q, state_q == S_FETCH1};
  assign dat_rd_o    = (state_q == S_LOAD);
  assign dat_addr_o  = DAW'(src_q + beat);
  assign bus_valid_o = (state_q == S_BEAT);
  assign bus_we_o    = (kind_q != K_READ);
  assign bus_ind_o   = ind_q;
  assign bus_last_o  = chunked_q ? chunk_end : final_beat;
  assign bus_addr_o  = w0_q[23:0] + 24'({beat, 2'b00});
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/rinit_checker.sv
module rinit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        cmd_rd_o,
  input logic        dat_rd_o,
  input logic        bus_valid_o,
  input logic        bus_ready_i,
  input logic        bus_we_o,
  input logic        bus_ind_o,
  input logic        bus_last_o,
  input logic [23:0] bus_addr_o,
  input logic [31:0] bus_wdata_o
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) &&
      $stable(bus_wdata_o) && $stable(bus_we_o) && $stable(bus_ind_o) && $stable(bus_last_o));

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_valid_o && !cmd_rd_o && !dat_rd_o);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  assert_read_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o && !bus_we_o |-> bus_last_o && !bus_ind_o);
endmodule

bind rinit_sequencer rinit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .cmd_rd_o(cmd_rd_o), .dat_rd_o(dat_rd_o), .bus_valid_o(bus_valid_o),
  .bus_ready_i(bus_ready_i), .bus_we_o(bus_we_o), .bus_ind_o(bus_ind_o),
  .bus_last_o(bus_last_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o)
);

// File: tb/sim_rinit_sequencer.sv
`timescale 1ns/1ps
module sim_rinit_sequencer;
  localparam int IDXW = 6, DAW = 8, MAXC = 4, STW = 16, NV = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IDXW-1:0] first_idx = '0, end_idx = '0;
  logic busy, done, err, cmd_rd, dat_rd, bvalid, bready = 1'b0, bwe, bind_q, blast;
  logic [IDXW:0] cmd_addr;
  logic [DAW-1:0] dat_addr;
  logic [31:0] cmd_q, dat_q, bwdata;
  logic [23:0] baddr;

  always #10 clk = ~clk;

  rinit_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .first_idx_i(first_idx), .end_idx_i(end_idx),
    .busy_o(busy), .done_o(done), .err_o(err), .cmd_rd_o(cmd_rd), .cmd_addr_o(cmd_addr),
    .cmd_data_i(cmd_q), .dat_rd_o(dat_rd), .dat_addr_o(dat_addr), .dat_data_i(dat_q),
    .bus_valid_o(bvalid), .bus_ready_i(bready), .bus_we_o(bwe), .bus_ind_o(bind_q),
    .bus_last_o(blast), .bus_addr_o(baddr), .bus_wdata_o(bwdata)
  );

  logic [31:0] cmem [128];
  logic [31:0] dmem [256];
  always @(posedge clk) if (cmd_rd) cmd_q <= cmem[cmd_addr];
  always @(posedge clk) if (dat_rd) dat_q <= dmem[dat_addr];

  logic [7:0] lfsr = 8'h5B;
  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bready <= lfsr[0] | lfsr[2];
  end

  int nlog = 0, ndone = 0;
  logic        l_we [512];
  logic        l_ind[512];
  logic        l_last[512];
  logic [23:0] l_addr[512];
  logic [31:0] l_data[512];
  always @(posedge clk) begin
    if (rst_n && bvalid && bready) begin
      l_we[nlog] <= bwe; l_ind[nlog] <= bind_q; l_last[nlog] <= blast;
      l_addr[nlog] <= baddr; l_data[nlog] <= bwdata;
      nlog <= nlog + 1;
    end
    if (rst_n && done) ndone <= ndone + 1;
  end

  int total = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op, offset, payload, expected beats, expected error
  localparam logic [72:0] VEC [NV] = '{
    {8'd1, 24'h000040, 32'h00000000,            8'd1,  1'b0},
    {8'd2, 24'h000080, 32'hDEADBEEF,            8'd1,  1'b0},
    {8'd3, 24'h000100, 32'h12345678,            8'd1,  1'b0},
    {8'd4, 24'h001000, {16'd3, 16'd5},          8'd3,  1'b0},
    {8'd5, 24'h002000, {16'd2, 16'd20},         8'd2,  1'b0},
    {8'd6, 24'h003000, 32'd6,                   8'd6,  1'b0},
    {8'd6, 24'h003100, 32'd8,                   8'd8,  1'b0},
    {8'd6, 24'h003200, 32'd17,                  8'd0,  1'b1},
    {8'd8, 24'h004000, {16'd5, 16'd10},         8'd5,  1'b0},
    {8'd8, 24'h004100, {16'd16, 16'd30},        8'd16, 1'b0},
    {8'd8, 24'h004200, {16'd17, 16'd0},         8'd0,  1'b1},
    {8'd7, 24'h005000, {16'd2, 16'd0},          8'd0,  1'b1},
    {8'd9, 24'h005100, 32'h00000001,            8'd0,  1'b1},
    {8'd4, 24'h005200, {16'd0, 16'd7},          8'd0,  1'b0},
    {8'd6, 24'h006000, 32'd16,                  8'd16, 1'b0},
    {8'd6, 24'h006100, 32'h00010000,            8'd0,  1'b1}
  };

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'd1: return "R2";
      8'd2, 8'd3: return "R3";
      8'd4, 8'd5: return "R4";
      8'd6: return "R5";
      8'd8: return "R6";
      default: return "R8";
    endcase
  endfunction

  bit timed_out = 0;
  task automatic run(input int f, input int e);
    int t;
    @(negedge clk);
    first_idx = IDXW'(f); end_idx = IDXW'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (!done) begin
      timed_out = 1;
      chk("R1 run timeout", 32'd0, 32'd1);
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = 32'hC0DE0000 + 32'(i) * 32'h00010003;
    for (int i = 0; i < 128; i++) cmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // reset state (R1, R11)
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R9 reset err", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 idle no valid", {31'd0, bvalid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] op; logic [23:0] off; logic [31:0] pay; int nb, n0, got;
      op = VEC[v][72:65]; off = VEC[v][64:41]; pay = VEC[v][40:9];
      nb = int'(VEC[v][8:1]);
      cmem[0] = {op, off}; cmem[1] = pay;
      n0 = nlog;
      run(0, 1);
      got = nlog - n0;
      chk({req_of(op), " beat count"}, 32'(got), 32'(nb));
      chk({(VEC[v][0] ? "R7/R8" : "R9"), " error flag"}, {31'd0, err}, {31'd0, VEC[v][0]});
      for (int k = 0; k < nb; k++) if (k < got) begin
        logic ewe, eind, elast; logic [31:0] edata; int len, src;
        ewe = (op != 8'd1); eind = (op == 8'd3) || (op == 8'd5);
        len = (op == 8'd6) ? int'(pay) : int'(pay[31:16]);
        src = int'(pay[15:0]);
        if (op <= 8'd3) begin elast = 1'b1; len = 1; end
        else if (op == 8'd4 || op == 8'd5) elast = (k == len - 1);
        else elast = (k % MAXC == MAXC - 1) || (k == len - 1);
        if (op == 8'd1 || op == 8'd6) edata = 32'd0;
        else if (op <= 8'd3) edata = pay;
        else edata = dmem[(src + k) % 256];
        chk({req_of(op), " addr"}, {8'd0, l_addr[n0+k]}, {8'd0, off + 24'(4*k)});
        chk({req_of(op), " we"}, {31'd0, l_we[n0+k]}, {31'd0, ewe});
        chk({req_of(op), " ind"}, {31'd0, l_ind[n0+k]}, {31'd0, eind});
        chk({req_of(op), " last"}, {31'd0, l_last[n0+k]}, {31'd0, elast});
        if (op != 8'd1) chk({req_of(op), " data"}, l_data[n0+k], edata);
      end
    end

    // R8 and R1: bad opcode mid-run, sequencing continues, end index exclusive
    begin
      int n0;
      cmem[4] = {8'hFF, 24'h0}; cmem[5] = 32'h0;
      cmem[6] = {8'd2, 24'h000100}; cmem[7] = 32'h11;
      cmem[8] = {8'd3, 24'h000200}; cmem[9] = 32'h22;
      cmem[10] = {8'd2, 24'h000300}; cmem[11] = 32'h33;
      n0 = nlog;
      run(2, 5);
      chk("R1 multi beat count", 32'(nlog - n0), 32'd2);
      chk("R8 err after bad op", {31'd0, err}, 32'd1);
      chk("R8 next cmd addr", {8'd0, l_addr[n0]}, 32'h100);
      chk("R3 indirect second", {31'd0, l_ind[n0+1]}, 32'd1);
      chk("R1 order data", l_data[n0+1], 32'h22);
    end
    // R9: new start clears error
    begin
      cmem[0] = {8'd2, 24'h40}; cmem[1] = 32'h5;
      run(0, 1);
      chk("R9 err cleared", {31'd0, err}, 32'd0);
    end
    // R1: empty range
    begin
      int n0, d0;
      n0 = nlog; d0 = ndone;
      run(3, 3);
      chk("R1 empty no beats", 32'(nlog - n0), 32'd0);
      chk("R1 empty done", 32'(ndone - d0), 32'd1);
    end
    // R11: start while busy is ignored
    begin
      int n0, d0;
      cmem[0] = {8'd6, 24'h7000}; cmem[1] = 32'd8;
      n0 = nlog; d0 = ndone;
      @(negedge clk);
      first_idx = 0; end_idx = 1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      first_idx = 2; end_idx = 5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (200) @(negedge clk);
      chk("R11 one done", 32'(ndone - d0), 32'd1);
      chk("R11 beats of first run only", 32'(nlog - n0), 32'd8);
      chk("R11 idle after", {31'd0, busy}, 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end
endmodule